// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Controller

This block gathers the interrupt sources of a serial port and turns them into one interrupt line. The transmit and receive paths drive a vector of event inputs, one bit per source. An event is recorded in a sticky pending register only when its mask bit is set. Software acknowledges a pending bit by writing 1 to it. The interrupt line is high while any pending bit is set.

The mask cannot be written directly. Software sets mask bits through a write-only set port and clears them through a write-only clear port. Both ports read back as zero. A separate read-only view shows the live FIFO level conditions, whatever the mask holds. The bus is a single-cycle valid/write/address/data interface. Read data is registered and appears one cycle after the read request.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask and pending registers are zero, the interrupt output is low and read data is zero.
- R2: A write to address 0 (set port) sets each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the matching mask bits as they were.
- R3: A write to address 1 (clear port) clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: Reads of address 0 and address 1 return zero. The mask reads at address 2, and a write to address 2 has no effect on it.
- R5: Only write-data bits 12:0 are used. Writes to higher bits have no effect, and those bits read back as zero.
- R6: Each register uses the same bit positions: 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing, 7 parity, 8 RX timeout. Event input bit n sets pending bit n one cycle later, but only if mask bit n is 1 in the cycle of the event.
- R7: A write to address 3 clears each pending bit whose write-data bit is 1. Pending bits written with 0 are unchanged. The pending register reads at address 3.
- R8: If an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when at least one pending bit is set.
- R10: Address 4 returns the live levels in the same positions as R6, whatever the mask holds. The level input bits map as follows: bit 0 to RX trigger (bit 0), bit 1 to RX empty (bit 1), bit 2 to TX empty (bit 3) and bit 3 to TX full (bit 4). All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the read request |
| evt_i | input | EV_W | Per-cycle event inputs, one per interrupt source |
| fifo_lvl_i | input | 4 | Live levels: {TX full, TX empty, RX empty, RX trigger} |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach from the ports is a pending bit that receives an event and an acknowledge in the same clock cycle. Only that case shows whether the event takes priority over the clear. The bench first makes the bit pending. It then issues the write-1-to-clear with the same event bit asserted during that write cycle, and reads the pending register back. The bench also shows that the write-only and read-only addresses leave the mask untouched, by reading the mask after each such write.

// File: rtl/irq_mask_ctrl_pkg.sv
// Package: register addresses, bit positions and write decode type for the
// interrupt mask controller. Assumes word-level addressing on the bus.
package irq_mask_ctrl_pkg;
    localparam int REG_SET  = 0;
    localparam int REG_CLR  = 1;
    localparam int REG_MASK = 2;
    localparam int REG_PEND = 3;
    localparam int REG_LIVE = 4;

    localparam int B_RX_TRIG  = 0;
    localparam int B_RX_EMPTY = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_EMPTY = 3;
    localparam int B_TX_FULL  = 4;
    localparam int B_OVERRUN  = 5;
    localparam int B_FRAMING  = 6;
    localparam int B_PARITY   = 7;
    localparam int B_RX_TMO   = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_ACK  = 2'd3
    } wr_op_e;
endpackage

// File: rtl/imc_decode.sv
// Bus decoder: turns one bus request into a write operation with its field
// bits, or a read request. Assumes single-cycle requests with no wait states.
module imc_decode
    import irq_mask_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int FIELD_W = 13
) (
    input  logic               valid,
    input  logic               write,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] field,
    output logic [FIELD_W-1:0] set_bits,
    output logic [FIELD_W-1:0] clr_bits,
    output logic [FIELD_W-1:0] ack_bits,
    output logic               rd_en
);
    wr_op_e op;

    // Classify the write target.
    always_comb begin
        op = OP_NONE;
        if (valid && write) begin
            if (addr == ADDR_W'(REG_SET))       op = OP_SET;
            else if (addr == ADDR_W'(REG_CLR))  op = OP_CLR;
            else if (addr == ADDR_W'(REG_PEND)) op = OP_ACK;
        end
    end

    // Route the field bits to the selected operation.
    always_comb begin
        set_bits = (op == OP_SET) ? field : '0;
        clr_bits = (op == OP_CLR) ? field : '0;
        ack_bits = (op == OP_ACK) ? field : '0;
    end

    assign rd_en = valid && !write;
endmodule

// File: rtl/imc_mask_reg.sv
// Mask register with separate set and clear inputs. When set and clear hit
// the same bit in one cycle, clear wins.
module imc_mask_reg #(
    parameter int FIELD_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] set_bits,
    input  logic [FIELD_W-1:0] clr_bits,
    output logic [FIELD_W-1:0] mask_q
);
    // Apply set first, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/imc_pend_reg.sv
// Sticky pending register, one flop per source. A masked event sets its bit
// and a write-1 acknowledge clears it. The event wins over the acknowledge.
module imc_pend_reg #(
    parameter int FIELD_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] evt,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] ack_bits,
    output logic [FIELD_W-1:0] pend_q
);
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        // Per-bit set/hold/clear with event priority.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= (evt[i] & mask[i]) | (pend_q[i] & ~ack_bits[i]);
        end
    end
endmodule

// File: rtl/imc_read_mux.sv
// Registered read port. The set and clear ports and any unmapped address
// return zero. The live view places the FIFO levels at their source positions.
module imc_read_mux
    import irq_mask_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] pend,
    input  logic [3:0]         lvl,
    output logic [DATA_W-1:0]  rdata
);
    logic [FIELD_W-1:0] live;

    // Place the live FIFO levels at their bit positions.
    always_comb begin
        live             = '0;
        live[B_RX_TRIG]  = lvl[0];
        live[B_RX_EMPTY] = lvl[1];
        live[B_TX_EMPTY] = lvl[2];
        live[B_TX_FULL]  = lvl[3];
    end

    // Capture read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                ADDR_W'(REG_MASK): rdata <= DATA_W'(mask);
                ADDR_W'(REG_PEND): rdata <= DATA_W'(pend);
                ADDR_W'(REG_LIVE): rdata <= DATA_W'(live);
                default:           rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Top of the interrupt mask controller. Connects the decoder, mask register,
// pending register and read port, and ORs the pending bits into irq_o.
// Assumes DATA_W >= FIELD_W >= EV_W.
module irq_mask_ctrl #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 13,
    parameter int EV_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EV_W-1:0]   evt_i,
    input  logic [3:0]        fifo_lvl_i,
    output logic              irq_o
);
    localparam int HI_W = DATA_W - FIELD_W;

    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] evt_ext;
    logic [FIELD_W-1:0] set_bits, clr_bits, ack_bits;
    logic [FIELD_W-1:0] mask_q, pend_q;
    logic               rd_en;
    logic [HI_W-1:0]    unused_hi;

    assign field     = bus_wdata[FIELD_W-1:0];
    assign unused_hi = bus_wdata[DATA_W-1:FIELD_W];
    assign evt_ext   = FIELD_W'(evt_i);

    imc_decode #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_dec (
        .valid(bus_valid), .write(bus_write), .addr(bus_addr), .field(field),
        .set_bits(set_bits), .clr_bits(clr_bits), .ack_bits(ack_bits), .rd_en(rd_en)
    );

    imc_mask_reg #(.FIELD_W(FIELD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits), .mask_q(mask_q)
    );

    imc_pend_reg #(.FIELD_W(FIELD_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(evt_ext), .mask(mask_q), .ack_bits(ack_bits), .pend_q(pend_q)
    );

    imc_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(bus_addr), .mask(mask_q),
        .pend(pend_q), .lvl(fifo_lvl_i), .rdata(bus_rdata)
    );

    // Interrupt line: any pending source.
    assign irq_o = |pend_q;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Checker for the interrupt mask controller, bound to the top module. It
// watches the bus, the events and the internal mask and pending state.
module irq_mask_ctrl_chk
    import irq_mask_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 13,
    parameter int EV_W    = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [EV_W-1:0]    evt_i,
    input logic [FIELD_W-1:0] mask_q,
    input logic [FIELD_W-1:0] pend_q
);
    logic [FIELD_W-1:0] f, ev, hit;
    logic wr_set, wr_clr, wr_ack;

    assign f      = bus_wdata[FIELD_W-1:0];
    assign ev     = FIELD_W'(evt_i);
    assign hit    = ev & mask_q;
    assign wr_set = bus_valid && bus_write && bus_addr == ADDR_W'(REG_SET);
    assign wr_clr = bus_valid && bus_write && bus_addr == ADDR_W'(REG_CLR);
    assign wr_ack = bus_valid && bus_write && bus_addr == ADDR_W'(REG_PEND);

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(f)) == $past(f)));
    assert_keep_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(f)) == '0));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(mask_q));
    assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));
    assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((pend_q & $past(f) & ~$past(hit)) == '0));
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .EV_W(EV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_i(evt_i),
    .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task queues expected values and a monitor
// compares them when read data returns.
module irq_mask_ctrl_bench;
    import irq_mask_ctrl_pkg::*;
    localparam int ADDR_W = 3, DATA_W = 32, FIELD_W = 13, EV_W = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [EV_W-1:0] evt_i = '0;
    logic [3:0] fifo_lvl_i = '0;
    logic irq_o;
    logic rd_pending = 1'b0;
    int checks = 0, errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    string tag_q[$];

    irq_mask_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .EV_W(EV_W)) u_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .fifo_lvl_i(fifo_lvl_i), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) rd_pending <= bus_valid && !bus_write;

    // Monitor: compare returned read data with the queued expectation.
    always @(negedge clk) begin
        if (rd_pending && exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input int a, input logic [DATA_W-1:0] d, input logic [EV_W-1:0] ev);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d; evt_i = ev;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; evt_i = '0;
    endtask

    task automatic rd(input int a, input logic [DATA_W-1:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input logic [EV_W-1:0] ev);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b", t, irq_o, e);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk_irq(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd(REG_MASK, 32'h0, "R1 mask after reset");
        rd(REG_PEND, 32'h0, "R1 pending after reset");
        chk_irq(1'b0, "R1 irq after reset");
        // R2: set port
        wr(REG_SET, 32'h0000_0109, '0);
        rd(REG_MASK, 32'h0000_0109, "R2 set bits");
        wr(REG_SET, 32'h0000_0002, '0);
        rd(REG_MASK, 32'h0000_010B, "R2 zeros keep bits");
        // R3: clear port
        wr(REG_CLR, 32'h0000_0008, '0);
        rd(REG_MASK, 32'h0000_0103, "R3 clear bit");
        // R4: write-only ports read zero, mask address is read-only
        rd(REG_SET, 32'h0, "R4 set port reads zero");
        rd(REG_CLR, 32'h0, "R4 clear port reads zero");
        wr(REG_MASK, 32'h0000_1FFF, '0);
        rd(REG_MASK, 32'h0000_0103, "R4 mask write ignored");
        // R5: upper bits ignored
        wr(REG_SET, 32'hFFFF_E000, '0);
        rd(REG_MASK, 32'h0000_0103, "R5 high bits ignored");
        wr(REG_SET, 32'hFFFF_FFFF, '0);
        rd(REG_MASK, 32'h0000_1FFF, "R5 full field");
        wr(REG_CLR, 32'hFFFF_FFFF, '0);
        rd(REG_MASK, 32'h0, "R3 clear all");
        // R6: events with mask zero are dropped
        pulse(9'h1FF);
        rd(REG_PEND, 32'h0, "R6 masked events dropped");
        chk_irq(1'b0, "R9 irq low with nothing pending");
        wr(REG_SET, 32'h0000_0103, '0);
        pulse(9'h1FF);
        rd(REG_PEND, 32'h0000_0103, "R6 masked capture");
        chk_irq(1'b1, "R9 irq high when pending");
        // R7: write-1-to-clear
        wr(REG_PEND, 32'h0000_0001, '0);
        rd(REG_PEND, 32'h0000_0102, "R7 ack one bit");
        wr(REG_PEND, 32'h0, '0);
        rd(REG_PEND, 32'h0000_0102, "R7 zero write keeps bits");
        wr(REG_PEND, 32'h0000_0102, '0);
        rd(REG_PEND, 32'h0, "R7 ack all");
        chk_irq(1'b0, "R9 irq low after ack");
        // R8: event and ack on the same bit in one cycle
        pulse(9'h100);
        wr(REG_PEND, 32'h0000_0100, 9'h100);
        rd(REG_PEND, 32'h0000_0100, "R8 event wins over ack");
        chk_irq(1'b1, "R9 irq stays high");
        wr(REG_PEND, 32'h0000_0100, '0);
        rd(REG_PEND, 32'h0, "R7 ack after collision");
        // R10: live view regardless of mask
        wr(REG_CLR, 32'h0000_1FFF, '0);
        fifo_lvl_i = 4'b1010;
        rd(REG_LIVE, 32'h0000_0012, "R10 live view pattern A");
        fifo_lvl_i = 4'b0101;
        rd(REG_LIVE, 32'h0000_0009, "R10 live view pattern B");
        fifo_lvl_i = 4'b1111;
        rd(REG_LIVE, 32'h0000_001B, "R10 live view all set");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule